// File: doc/BRIEF.md
# Clock Output Source-Select Divider

This block produces one programmable output clock and one fixed-ratio auxiliary clock. A 3-bit source code picks one of seven source clocks: the reference or the in-phase or inverted phase of one of three PLLs. The chosen source is divided by a 7-bit ratio taken from one of two divider banks, and a bank-select input picks the bank. A second path divides the in-phase PLL1 clock by 2, 3 or 4 under a 2-bit code. Both paths give a 50% duty cycle for every ratio, including odd ones.

The source clocks reach the block as levels. A two-stage synchronizer brings them into a faster system clock domain, and the dividers count both edges of the selected level there. A ratio of zero, a disabled PLL or the active-low float input removes the output enable, which stands for a tri-stated pad. A new divider value, whether it comes from a bank change or from a rewritten bank, is only taken up at the end of the current output period. No pulse is therefore ever shorter than the shorter of the old and new half-periods.

Top module: `clkout_divsel`

## Requirements
- R1: The source code selects the source: 000 reference (`src_lvl[0]`), 010/011 PLL1 (`src_lvl[1]`), 100/101 PLL2 (`src_lvl[2]`), 110/111 PLL3 (`src_lvl[3]`). The output period follows the selected source.
- R2: An even source code picks the in-phase source and an odd code (other than 001) picks the inverted source. With a ratio of 1, the output is high three system cycles after a rising source edge for the in-phase code and low for the inverted code.
- R3: For a ratio N from 1 to 127, the output is high for N source half-periods and low for N source half-periods, so odd ratios also give a 50% duty cycle.
- R4: While the active ratio is zero, `clk_oe` and `clk_out` are low.
- R5: `bank_sel` = 0 picks `div_bank0` and 1 picks `div_bank1`. A changed ratio takes effect at the first rising output edge after the current period ends. The low phase in progress keeps the old ratio, and no pulse is cut short.
- R6: When the PLL behind the selected source has its `pll_en` bit (bit 0 = PLL1, 1 = PLL2, 2 = PLL3) low, `clk_oe` is low. The enable bits of other PLLs have no effect on that output. `post_oe` is low whenever `pll_en[0]` is low.
- R7: While `float_n` is low, `clk_oe`, `post_oe` and both data outputs are low.
- R8: Source code 001 holds `clk_out` low while `clk_oe` stays high.
- R9: The auxiliary code maps 00 to off (`post_oe` low), 01 to /4, 10 to /2 and 11 to /3 of the in-phase PLL1 clock, each with a 50% duty cycle. A code change takes effect at the end of the current auxiliary period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the source levels |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_lvl | input | 4 | Source clock levels: reference, PLL1, PLL2, PLL3 |
| pll_en | input | 3 | Per-PLL enable, bit 0 = PLL1 |
| float_n | input | 1 | Active low: tri-states both outputs |
| sel_code | input | 3 | Source select code |
| div_bank0 | input | 7 | Divider ratio, bank 0 |
| div_bank1 | input | 7 | Divider ratio, bank 1 |
| bank_sel | input | 1 | Divider bank select |
| post_code | input | 2 | Auxiliary divider code |
| clk_out | output | 1 | Divided output clock (low when not enabled) |
| clk_oe | output | 1 | Pad enable for clk_out |
| post_out | output | 1 | Auxiliary divided clock (low when not enabled) |
| post_oe | output | 1 | Pad enable for post_out |

## Verification
Each source runs at its own half-period (3, 4, 5 and 6 system cycles), so a measured pulse width of N times that half-period shows both that the right source was picked and that the ratio was applied. Ratios 1, 4, 7 and 127 separate exact-ratio errors from duty errors on odd values and from errors at the range ends. Running the same PLL through its in-phase and inverted codes at ratio 1 tells the two phases apart. A bank switch made during a high phase separates a change at the terminal count from an immediate change, by the width of the low phase that follows.

// File: rtl/clkout_divsel_pkg.sv
`timescale 1ns/1ps
package clkout_divsel_pkg;

  localparam int unsigned CODE_W = 3;
  localparam int unsigned N_GRP  = 2 ** (CODE_W - 1);

  typedef enum logic [CODE_W-1:0] {
    SRC_REF    = 3'b000,
    SRC_RSVD   = 3'b001,
    SRC_P1_0   = 3'b010,
    SRC_P1_180 = 3'b011,
    SRC_P2_0   = 3'b100,
    SRC_P2_180 = 3'b101,
    SRC_P3_0   = 3'b110,
    SRC_P3_180 = 3'b111
  } src_code_e;

  typedef enum logic [1:0] {
    AUX_OFF  = 2'b00,
    AUX_DIV4 = 2'b01,
    AUX_DIV2 = 2'b10,
    AUX_DIV3 = 2'b11
  } aux_code_e;

  // Ratio applied by the auxiliary divider for each code; zero means off.
  function automatic logic [2:0] aux_ratio(input logic [1:0] code);
    logic [2:0] r;
    case (code)
      AUX_DIV4: r = 3'd4;
      AUX_DIV2: r = 3'd2;
      AUX_DIV3: r = 3'd3;
      default:  r = 3'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/src_sync.sv
`timescale 1ns/1ps
module src_sync #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] lvl_in,
  output logic [N_SRC-1:0] lvl_out
);

  logic [N_SRC-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= lvl_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign lvl_out = stage_q[STAGES-1];

endmodule

// File: rtl/src_pick.sv
`timescale 1ns/1ps
module src_pick
  import clkout_divsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic [N_GRP-1:0]  lvl,
  input  logic [N_GRP-2:0]  pll_en,
  output logic              rise,
  output logic              edge_any,
  output logic              valid,
  output logic              reserved
);

  logic [CODE_W-2:0] grp;
  logic [N_GRP-1:0]  en_vec;
  logic              sel_d;
  logic              sel_q;

  always_comb begin
    grp      = code[CODE_W-1:1];
    en_vec   = {pll_en, 1'b1};
    reserved = (code == SRC_RSVD);
    valid    = en_vec[grp];
    sel_d    = reserved ? 1'b0 : (lvl[grp] ^ code[0]);
    rise     = sel_d & ~sel_q;
    edge_any = sel_d ^ sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

endmodule

// File: rtl/ratio_div.sv
`timescale 1ns/1ps
module ratio_div #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         rise,
  input  logic         edge_any,
  input  logic [W-1:0] req,
  output logic         q,
  output logic [W-1:0] act,
  output logic         live,
  output logic         wrap
);

  localparam int unsigned CW = W + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt, cnt_n, cnt_inc, last;
  logic [W-1:0]  act_n;
  logic          q_n, live_n;
  logic          act_zero;

  always_comb begin
    act_zero = (act == '0);
    last     = {act, 1'b0} - ONE;
    cnt_inc  = cnt + ONE;
    wrap     = run & live & edge_any & (cnt == last);
  end

  // Counts both edges of the source: 2*act edges per output period,
  // high for the first act of them. New ratios load only at the wrap.
  always_comb begin
    act_n  = act;
    cnt_n  = cnt;
    q_n    = q;
    live_n = live;
    if (!run || act_zero) begin
      act_n  = req;
      cnt_n  = '0;
      q_n    = 1'b0;
      live_n = 1'b0;
    end else if (!live) begin
      act_n = req;
      if (rise && (req != '0)) begin
        live_n = 1'b1;
        cnt_n  = '0;
        q_n    = 1'b1;
      end
    end else if (edge_any) begin
      if (cnt == last) begin
        act_n  = req;
        cnt_n  = '0;
        q_n    = (req != '0);
        live_n = (req != '0);
      end else begin
        cnt_n = cnt_inc;
        q_n   = (cnt_inc < {1'b0, act});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= '0;
      cnt  <= '0;
      q    <= 1'b0;
      live <= 1'b0;
    end else begin
      act  <= act_n;
      cnt  <= cnt_n;
      q    <= q_n;
      live <= live_n;
    end
  end

endmodule

// File: rtl/clkout_divsel.sv
`timescale 1ns/1ps
module clkout_divsel
  import clkout_divsel_pkg::*;
#(
  parameter int unsigned DIV_W       = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GRP-1:0]  src_lvl,
  input  logic [N_GRP-2:0]  pll_en,
  input  logic              float_n,
  input  logic [CODE_W-1:0] sel_code,
  input  logic [DIV_W-1:0]  div_bank0,
  input  logic [DIV_W-1:0]  div_bank1,
  input  logic              bank_sel,
  input  logic [1:0]        post_code,
  output logic              clk_out,
  output logic              clk_oe,
  output logic              post_out,
  output logic              post_oe
);

  localparam int unsigned POST_W = 3;

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [N_GRP-1:0] lvl_s;

  src_sync #(.N_SRC(N_GRP), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lvl_in  (src_lvl),
    .lvl_out (lvl_s)
  );

  // Main path
  logic             main_rise, main_edge, main_valid, main_rsvd, main_run;
  logic             main_q, main_live, main_wrap;
  logic [DIV_W-1:0] main_req, main_act;

  src_pick u_main_pick (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .code     (sel_code),
    .lvl      (lvl_s),
    .pll_en   (pll_en),
    .rise     (main_rise),
    .edge_any (main_edge),
    .valid    (main_valid),
    .reserved (main_rsvd)
  );

  assign main_req = bank_sel ? div_bank1 : div_bank0;
  assign main_run = main_valid & ~main_rsvd;

  ratio_div #(.W(DIV_W)) u_main_div (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (main_run),
    .rise     (main_rise),
    .edge_any (main_edge),
    .req      (main_req),
    .q        (main_q),
    .act      (main_act),
    .live     (main_live),
    .wrap     (main_wrap)
  );

  assign clk_oe  = float_n & main_valid & (main_act != '0);
  assign clk_out = clk_oe & main_q;

  // Auxiliary path: fixed in-phase PLL1 source
  logic              post_rise, post_edge, post_valid, post_rsvd, post_run;
  logic              post_q, post_live, post_wrap;
  logic [POST_W-1:0] post_req, post_act;

  src_pick u_post_pick (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .code     (SRC_P1_0),
    .lvl      (lvl_s),
    .pll_en   (pll_en),
    .rise     (post_rise),
    .edge_any (post_edge),
    .valid    (post_valid),
    .reserved (post_rsvd)
  );

  assign post_req = aux_ratio(post_code);
  assign post_run = post_valid & ~post_rsvd;

  ratio_div #(.W(POST_W)) u_post_div (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (post_run),
    .rise     (post_rise),
    .edge_any (post_edge),
    .req      (post_req),
    .q        (post_q),
    .act      (post_act),
    .live     (post_live),
    .wrap     (post_wrap)
  );

  assign post_oe  = float_n & post_valid & (post_act != '0);
  assign post_out = post_oe & post_q;

endmodule

// File: rtl/clkout_divsel_chk.sv
`timescale 1ns/1ps
module clkout_divsel_chk #(
  parameter int unsigned DIV_W  = 7,
  parameter int unsigned POST_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              float_n,
  input logic [2:0]        sel_code,
  input logic [2:0]        pll_en,
  input logic              clk_out,
  input logic              clk_oe,
  input logic              post_oe,
  input logic [DIV_W-1:0]  main_act,
  input logic              main_live,
  input logic              main_run,
  input logic              main_wrap,
  input logic              main_q,
  input logic              main_edge,
  input logic [POST_W-1:0] post_act,
  input logic              post_live,
  input logic              post_run,
  input logic              post_wrap
);

  logic [3:0] en_vec;
  assign en_vec = {pll_en, 1'b1};

  // R4
  zero_ratio_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_act == '0) |-> !clk_oe);

  // R7
  float_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !float_n |-> (!clk_oe && !post_oe));

  // R6
  pll_off_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_vec[sel_code[2:1]] |-> !clk_oe);

  // R6
  pll_off_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en[0] |-> !post_oe);

  // R8
  reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code == 3'b001) |=> !clk_out);

  // R5
  bank_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(main_live) && $past(main_run) && (main_act != $past(main_act)))
      |-> $past(main_wrap));

  // R9
  aux_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(post_live) && $past(post_run) && (post_act != $past(post_act)))
      |-> $past(post_wrap));

  // R3
  out_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(main_run) && (main_q != $past(main_q))) |-> $past(main_edge));

endmodule

bind clkout_divsel clkout_divsel_chk #(.DIV_W(DIV_W), .POST_W(POST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .float_n   (float_n),
  .sel_code  (sel_code),
  .pll_en    (pll_en),
  .clk_out   (clk_out),
  .clk_oe    (clk_oe),
  .post_oe   (post_oe),
  .main_act  (main_act),
  .main_live (main_live),
  .main_run  (main_run),
  .main_wrap (main_wrap),
  .main_q    (main_q),
  .main_edge (main_edge),
  .post_act  (post_act),
  .post_live (post_live),
  .post_run  (post_run),
  .post_wrap (post_wrap)
);

// File: tb/clkout_divsel_tb_top.sv
`timescale 1ns/1ps
module clkout_divsel_tb_top;

  logic       clk;
  logic       rst_n;
  logic [3:0] src;
  logic [2:0] pll_en;
  logic       float_n;
  logic [2:0] sel_code;
  logic [6:0] div_bank0, div_bank1;
  logic       bank_sel;
  logic [1:0] post_code;
  logic       clk_out, clk_oe, post_out, post_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Source half-periods in system cycles: ref, PLL1, PLL2, PLL3
  localparam int H0 = 3, H1 = 4, H2 = 5, H3 = 6;

  clkout_divsel dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl   (src),
    .pll_en    (pll_en),
    .float_n   (float_n),
    .sel_code  (sel_code),
    .div_bank0 (div_bank0),
    .div_bank1 (div_bank1),
    .bank_sel  (bank_sel),
    .post_code (post_code),
    .clk_out   (clk_out),
    .clk_oe    (clk_oe),
    .post_out  (post_out),
    .post_oe   (post_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial src = 4'b0000;
  always begin repeat (H0) @(negedge clk); src[0] = ~src[0]; end
  always begin repeat (H1) @(negedge clk); src[1] = ~src[1]; end
  always begin repeat (H2) @(negedge clk); src[2] = ~src[2]; end
  always begin repeat (H3) @(negedge clk); src[3] = ~src[3]; end

  function automatic int half_of(input int g);
    case (g)
      0: return H0;
      1: return H1;
      2: return H2;
      default: return H3;
    endcase
  endfunction

  function automatic logic sig(input int which);
    return (which == 0) ? clk_out : post_out;
  endfunction

  task automatic chk(input string tag, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wait_rise(input int which);
    int guard = 0;
    while (sig(which) == 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
    while (sig(which) == 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic count_level(input int which, input logic lvl, output int n);
    n = 0;
    while (sig(which) == lvl && n < 5000) begin n++; @(negedge clk); end
  endtask

  // Skips two output periods, then returns one high and one low width.
  task automatic measure(input int which, output int hi, output int lo);
    wait_rise(which);
    @(negedge clk);
    wait_rise(which);
    count_level(which, 1'b1, hi);
    count_level(which, 1'b0, lo);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pll_en = 3'b111; float_n = 1'b1; sel_code = 3'b000;
    div_bank0 = 7'd0; div_bank1 = 7'd0; bank_sel = 1'b0; post_code = 2'b00;
    wait_cyc(4);
    chk("R4 reset clk_oe", int'(clk_oe), 0);
    chk("R9 reset post_oe", int'(post_oe), 0);
    chk("R4 reset clk_out", int'(clk_out), 0);
    rst_n = 1'b1;
    wait_cyc(10);
    chk("R4 zero ratio after reset clk_oe", int'(clk_oe), 0);
  endtask

  task automatic t_sources();
    int hi, lo;
    logic [2:0] codes [4] = '{3'b000, 3'b010, 3'b100, 3'b110};
    div_bank0 = 7'd2;
    for (int g = 0; g < 4; g++) begin
      sel_code = codes[g];
      measure(0, hi, lo);
      chk($sformatf("R1 src %0d high", g), hi, 2 * half_of(g));
      chk($sformatf("R1 src %0d low", g), lo, 2 * half_of(g));
    end
  endtask

  task automatic phase_one(input logic [2:0] code, input int g, input int exp);
    div_bank0 = 7'd0;
    wait_cyc(40);
    sel_code  = code;
    div_bank0 = 7'd1;
    wait_cyc(60);
    @(posedge src[g]);
    wait_cyc(3);
    chk($sformatf("R2 phase code %0d", code), int'(clk_out), exp);
  endtask

  task automatic t_phase();
    phase_one(3'b010, 1, 1);
    phase_one(3'b011, 1, 0);
    phase_one(3'b100, 2, 1);
    phase_one(3'b101, 2, 0);
  endtask

  task automatic t_ratios();
    int hi, lo;
    int ns [4] = '{1, 4, 7, 127};
    sel_code = 3'b000;
    for (int i = 0; i < 4; i++) begin
      div_bank0 = 7'(ns[i]);
      measure(0, hi, lo);
      chk($sformatf("R3 ratio %0d high", ns[i]), hi, ns[i] * H0);
      chk($sformatf("R3 ratio %0d low", ns[i]), lo, ns[i] * H0);
    end
  endtask

  task automatic t_bank();
    int hi, lo, rest, lo1, hi2, lo2;
    sel_code = 3'b100; div_bank0 = 7'd3; div_bank1 = 7'd5; bank_sel = 1'b0;
    measure(0, hi, lo);
    chk("R5 bank0 high", hi, 3 * H2);
    wait_cyc(5);
    bank_sel = 1'b1;
    count_level(0, 1'b1, rest);
    count_level(0, 1'b0, lo1);
    count_level(0, 1'b1, hi2);
    count_level(0, 1'b0, lo2);
    chk("R5 high in progress not cut", rest + 5, 3 * H2);
    chk("R5 low keeps old ratio", lo1, 3 * H2);
    chk("R5 new high", hi2, 5 * H2);
    chk("R5 new low", lo2, 5 * H2);
  endtask

  task automatic t_zero();
    bank_sel = 1'b0; sel_code = 3'b000; div_bank0 = 7'd2; div_bank1 = 7'd2;
    wait_cyc(40);
    chk("R4 running oe", int'(clk_oe), 1);
    div_bank0 = 7'd0;
    wait_cyc(50);
    chk("R4 zero clk_oe", int'(clk_oe), 0);
    chk("R4 zero clk_out", int'(clk_out), 0);
  endtask

  task automatic t_reserved();
    int highs = 0;
    div_bank0 = 7'd3;
    sel_code  = 3'b001;
    wait_cyc(20);
    for (int i = 0; i < 100; i++) begin
      if (clk_out) highs++;
      @(negedge clk);
    end
    chk("R8 reserved high samples", highs, 0);
    chk("R8 reserved clk_oe", int'(clk_oe), 1);
  endtask

  task automatic t_post();
    int hi, lo;
    post_code = 2'b01;
    measure(1, hi, lo);
    chk("R9 div4 high", hi, 4 * H1);
    chk("R9 div4 low", lo, 4 * H1);
    post_code = 2'b10;
    measure(1, hi, lo);
    chk("R9 div2 high", hi, 2 * H1);
    post_code = 2'b11;
    measure(1, hi, lo);
    chk("R9 div3 high", hi, 3 * H1);
    chk("R9 div3 low", lo, 3 * H1);
    post_code = 2'b00;
    wait_cyc(60);
    chk("R9 off post_oe", int'(post_oe), 0);
  endtask

  task automatic t_pll_off();
    post_code = 2'b10; sel_code = 3'b100; div_bank0 = 7'd2;
    wait_cyc(40);
    pll_en = 3'b101;
    wait_cyc(2);
    chk("R6 PLL2 off clk_oe", int'(clk_oe), 0);
    chk("R6 PLL2 off leaves post_oe", int'(post_oe), 1);
    pll_en = 3'b110;
    wait_cyc(2);
    chk("R6 PLL1 off post_oe", int'(post_oe), 0);
    chk("R6 PLL1 off leaves clk_oe", int'(clk_oe), 1);
    pll_en = 3'b111;
    wait_cyc(40);
  endtask

  task automatic t_float();
    float_n = 1'b0;
    wait_cyc(1);
    chk("R7 float clk_oe", int'(clk_oe), 0);
    chk("R7 float post_oe", int'(post_oe), 0);
    chk("R7 float clk_out", int'(clk_out), 0);
    chk("R7 float post_out", int'(post_out), 0);
    float_n = 1'b1;
    wait_cyc(1);
    chk("R7 release clk_oe", int'(clk_oe), 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sources();
    t_phase();
    t_ratios();
    t_bank();
    t_zero();
    t_reserved();
    t_post();
    t_pll_off();
    t_float();
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule